// File: doc/BRIEF.md
# Charger Protection Fault Sequencer

This controller decides, once per clock, whether the power switch in a battery charge path may conduct. Its inputs are comparator flags that have already been digitised: input supply good, input over-voltage, battery over-voltage, over-temperature and reverse-voltage lockout. Each flag is synchronised, then passed through the timing rule for its fault class. Power-up is blanked, input over-voltage has a recovery wait, and a battery over-voltage has to persist for a qualification time before it counts. The combined result drives one registered switch-enable output.

Every qualified battery over-voltage is counted. When the count reaches its limit the switch is held off for good. Only a fall of input power followed by a new power-up sequence clears that state. The present fault cause, the event count and the latched-off state are visible on output ports at all times. All timer lengths are parameters given in clock cycles.

Top module: `chgGuard`

## Requirements
- R1: While reset is asserted, swEn is 0, faultCause is 2 (power not ready), batOvCount is 0 and lockedOff is 0.
- R2: Each flag passes through two synchronising flops, and swEn is registered. An input over-voltage, over-temperature or reverse-lockout flag that rises therefore drives swEn low at the third rising edge after the change.
- R3: After pgIn rises, with no fault present, swEn rises at the (BLANK_CYC+3)-th rising edge, and not before.
- R4: After inOvIn falls, swEn rises only once the flag has stayed low long enough: at the (RECOV_CYC+3)-th edge after the fall. If the flag rises again inside that window, the wait starts over.
- R5: A battery over-voltage pulse shorter than BQUAL_CYC cycles has no effect on swEn or batOvCount. A pulse that lasts BQUAL_CYC cycles or longer turns swEn off.
- R6: After a qualified battery over-voltage, swEn returns once batOvIn falls, at the fourth rising edge after the fall.
- R7: Each qualified battery over-voltage adds exactly one to batOvCount, however long the flag stays high.
- R8: When batOvCount reaches LATCH_COUNT (default 16), lockedOff becomes 1, the count stops, and swEn stays 0 whatever the other flags do.
- R9: A low level on pgIn clears batOvCount and lockedOff. Enabling then requires the full power-up blanking again.
- R10: Over-temperature turns swEn off. swEn comes back when the flag clears, so a repeating flag gives pulsed operation.
- R11: faultCause codes are 0 none, 1 latched off, 2 power not ready or blanking, 3 input over-voltage or its recovery, 4 over-temperature, 5 qualified battery over-voltage, 6 reverse lockout. When several causes are present, the one reported is the first in this order: 1, 2, 3, 4, 5, 6.
- R12: swEn is 1 exactly when faultCause is 0. Both change on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pgIn | input | 1 | Input supply good flag (asynchronous) |
| inOvIn | input | 1 | Input over-voltage flag (asynchronous) |
| batOvIn | input | 1 | Battery over-voltage flag (asynchronous) |
| hotIn | input | 1 | Over-temperature flag (asynchronous) |
| revLockIn | input | 1 | Reverse-voltage lockout flag (asynchronous) |
| swEn | output | 1 | Registered power switch enable |
| faultCause | output | 3 | Current fault cause code (R11) |
| batOvCount | output | CNT_W (5) | Qualified battery over-voltage events |
| lockedOff | output | 1 | Permanent latch-off indicator |

## Verification
The immediate faults (input over-voltage, over-temperature, lockout) reach swEn and faultCause three edges after the flag changes: two synchroniser flops and the output register. The timed results are due later. Power-up enable comes BLANK_CYC+3 edges after pgIn rises, and over-voltage recovery RECOV_CYC+3 edges after inOvIn falls. A battery fault turns the switch off BQUAL_CYC+3 edges after batOvIn rises, and the count increments on that same edge. The bench drives inputs on falling edges, and its cycle model advances at each rising edge in the same register order. All outputs are compared at the following falling edge, and the directed checks read the output exactly at the edge where a result is due and one edge before it.

// File: rtl/chgGuardPkg.sv
package chgGuardPkg;

  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_LATCHED = 3'd1,
    CAUSE_POWER   = 3'd2,
    CAUSE_INOV    = 3'd3,
    CAUSE_HOT     = 3'd4,
    CAUSE_BATOV   = 3'd5,
    CAUSE_REVLOCK = 3'd6
  } cause_e;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic blankClr;
    logic blankRun;
    logic recClr;
    logic recRun;
    logic qualClr;
    logic qualRun;
    logic evtInc;
    logic evtClr;
  } tmrCmd_t;

endpackage

// File: rtl/chgGuardSync.sv
module chgGuardSync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/chgGuardSatTimer.sv
module chgGuardSatTimer #(
  parameter int LIMIT    = 8,
  parameter bit RST_FULL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  input  logic run,
  output logic done
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 cnt <= RST_FULL ? LIM : '0;
    else if (clr)              cnt <= '0;
    else if (run && cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIM);
endmodule

// File: rtl/chgGuardTimers.sv
module chgGuardTimers
  import chgGuardPkg::*;
#(
  parameter int BLANK_CYC   = 40,
  parameter int RECOV_CYC   = 30,
  parameter int BQUAL_CYC   = 12,
  parameter int LATCH_COUNT = 16,
  parameter int CNT_W       = $clog2(LATCH_COUNT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrCmd_t          cmd,
  output logic             blankDone,
  output logic             recDone,
  output logic             qualDone,
  output logic [CNT_W-1:0] evtCount,
  output logic             latched
);
  localparam logic [CNT_W-1:0] LATCH_V = CNT_W'(LATCH_COUNT);

  chgGuardSatTimer #(.LIMIT(BLANK_CYC), .RST_FULL(1'b0)) uBlank (
    .clk(clk), .rstN(rstN), .clr(cmd.blankClr), .run(cmd.blankRun), .done(blankDone));

  chgGuardSatTimer #(.LIMIT(RECOV_CYC), .RST_FULL(1'b1)) uRecov (
    .clk(clk), .rstN(rstN), .clr(cmd.recClr), .run(cmd.recRun), .done(recDone));

  chgGuardSatTimer #(.LIMIT(BQUAL_CYC), .RST_FULL(1'b0)) uQual (
    .clk(clk), .rstN(rstN), .clr(cmd.qualClr), .run(cmd.qualRun), .done(qualDone));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               evtCount <= '0;
    else if (cmd.evtClr)                     evtCount <= '0;
    else if (cmd.evtInc && evtCount != LATCH_V) evtCount <= evtCount + 1'b1;
  end

  assign latched = (evtCount == LATCH_V);

  // R7: the event count moves only by one step up, or back to zero
  p_count_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (evtCount != $past(evtCount)) |->
      (evtCount == CNT_W'($past(evtCount) + 1'b1) || evtCount == '0));

  // R9: a power clear strobe empties the count
  p_power_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    cmd.evtClr |=> (evtCount == '0));
endmodule

// File: rtl/chgGuardCtrl.sv
module chgGuardCtrl
  import chgGuardPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sPg,
  input  logic    sOv,
  input  logic    sBat,
  input  logic    sHot,
  input  logic    sLock,
  input  logic    blankDone,
  input  logic    recDone,
  input  logic    qualDone,
  input  logic    latched,
  output tmrCmd_t cmd,
  output logic    swEn,
  output cause_e  cause
);
  logic   qualSeen;
  cause_e nextCause;

  always_comb begin
    cmd.blankClr = !sPg;
    cmd.blankRun = sPg && !blankDone;
    cmd.recClr   = sOv;
    cmd.recRun   = !sOv && !recDone;
    cmd.qualClr  = !sBat;
    cmd.qualRun  = sBat && !qualDone;
    cmd.evtInc   = qualDone && !qualSeen && !latched;
    cmd.evtClr   = !sPg;
  end

  always_comb begin
    if (latched)                    nextCause = CAUSE_LATCHED;
    else if (!sPg || !blankDone)    nextCause = CAUSE_POWER;
    else if (sOv || !recDone)       nextCause = CAUSE_INOV;
    else if (sHot)                  nextCause = CAUSE_HOT;
    else if (qualDone)              nextCause = CAUSE_BATOV;
    else if (sLock)                 nextCause = CAUSE_REVLOCK;
    else                            nextCause = CAUSE_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qualSeen <= 1'b0;
      swEn     <= 1'b0;
      cause    <= CAUSE_POWER;
    end else begin
      qualSeen <= sBat ? (qualSeen || qualDone) : 1'b0;
      swEn     <= (nextCause == CAUSE_NONE);
      cause    <= nextCause;
    end
  end

  // R2: a synchronised input over-voltage forces the switch off next edge
  p_ov_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    sOv |=> !swEn);

  // R10: over-temperature forces the switch off next edge
  p_hot_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    sHot |=> !swEn);

  // R5: a qualified battery fault from the timers keeps the switch off
  p_bat_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    qualDone |=> !swEn);

  // R8: once the datapath reports latch-off the switch never conducts
  p_latch_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    latched |=> !swEn);
endmodule

// File: rtl/chgGuard.sv
module chgGuard
  import chgGuardPkg::*;
#(
  parameter int BLANK_CYC   = 40,
  parameter int RECOV_CYC   = 30,
  parameter int BQUAL_CYC   = 12,
  parameter int LATCH_COUNT = 16,
  parameter int CNT_W       = $clog2(LATCH_COUNT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pgIn,
  input  logic             inOvIn,
  input  logic             batOvIn,
  input  logic             hotIn,
  input  logic             revLockIn,
  output logic             swEn,
  output logic [2:0]       faultCause,
  output logic [CNT_W-1:0] batOvCount,
  output logic             lockedOff
);
  logic [4:0] syncOut;
  tmrCmd_t    cmd;
  logic       blankDone, recDone, qualDone, latched;
  cause_e     cause;

  chgGuardSync #(.W(5)) uSync (
    .clk(clk), .rstN(rstN),
    .din({revLockIn, hotIn, batOvIn, inOvIn, pgIn}),
    .dout(syncOut));

  chgGuardCtrl uCtrl (
    .clk(clk), .rstN(rstN),
    .sPg(syncOut[0]), .sOv(syncOut[1]), .sBat(syncOut[2]),
    .sHot(syncOut[3]), .sLock(syncOut[4]),
    .blankDone(blankDone), .recDone(recDone), .qualDone(qualDone),
    .latched(latched), .cmd(cmd), .swEn(swEn), .cause(cause));

  chgGuardTimers #(
    .BLANK_CYC(BLANK_CYC), .RECOV_CYC(RECOV_CYC), .BQUAL_CYC(BQUAL_CYC),
    .LATCH_COUNT(LATCH_COUNT), .CNT_W(CNT_W)
  ) uTimers (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .blankDone(blankDone), .recDone(recDone), .qualDone(qualDone),
    .evtCount(batOvCount), .latched(latched));

  assign faultCause = cause;
  assign lockedOff  = latched;
endmodule

// File: tb/tb_chgGuard.sv
module tb_chgGuard;
  localparam int BLANK = 40, RECOV = 30, BQUAL = 12, NLATCH = 16, CW = 5;

  logic clk = 1'b0, rstN = 1'b0;
  logic pg = 0, ov = 0, bat = 0, hot = 0, lock = 0;
  logic swEn, lockedOff;
  logic [2:0] faultCause;
  logic [CW-1:0] batOvCount;

  always #5 clk = ~clk;

  chgGuard #(.BLANK_CYC(BLANK), .RECOV_CYC(RECOV), .BQUAL_CYC(BQUAL),
             .LATCH_COUNT(NLATCH), .CNT_W(CW)) dut (
    .clk(clk), .rstN(rstN), .pgIn(pg), .inOvIn(ov), .batOvIn(bat),
    .hotIn(hot), .revLockIn(lock), .swEn(swEn), .faultCause(faultCause),
    .batOvCount(batOvCount), .lockedOff(lockedOff));

  int nChecks = 0, nFails = 0;

  // cycle model of the requirements
  logic [4:0] m1, m2;
  int pgCnt, quiet, batCnt, events, expCause;
  bit seen, expEn;

  task automatic modelReset();
    m1 = '0; m2 = '0; pgCnt = 0; quiet = RECOV; batCnt = 0; events = 0;
    seen = 0; expEn = 0; expCause = 2;
  endtask

  function automatic int causeOf();
    if (events >= NLATCH)              return 1;
    if (!m2[0] || pgCnt != BLANK)      return 2;
    if (m2[1] || quiet != RECOV)       return 3;
    if (m2[3])                         return 4;
    if (batCnt == BQUAL)               return 5;
    if (m2[4])                         return 6;
    return 0;
  endfunction

  task automatic modelEdge();
    expCause = causeOf();
    expEn = (expCause == 0);
    if (!m2[0]) events = 0;
    else if (batCnt == BQUAL && !seen && events < NLATCH) events++;
    seen   = m2[2] ? (seen || batCnt == BQUAL) : 1'b0;
    pgCnt  = m2[0] ? ((pgCnt < BLANK) ? pgCnt + 1 : BLANK) : 0;
    quiet  = m2[1] ? 0 : ((quiet < RECOV) ? quiet + 1 : RECOV);
    batCnt = m2[2] ? ((batCnt < BQUAL) ? batCnt + 1 : BQUAL) : 0;
    m2 = m1;
    m1 = {lock, hot, bat, ov, pg};
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareAll(string req);
    bit ok;
    ok = (swEn == expEn) && (int'(faultCause) == expCause) &&
         (int'(batOvCount) == events) && (lockedOff == (events >= NLATCH));
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s outputs actual en=%0d cause=%0d cnt=%0d lock=%0d expected en=%0d cause=%0d cnt=%0d lock=%0d at %0t",
               req, swEn, faultCause, batOvCount, lockedOff,
               expEn, expCause, events, (events >= NLATCH), $time);
    end
  endtask

  task automatic step(int n, string req);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      modelEdge();
      @(negedge clk);
      compareAll(req);
    end
  endtask

  initial begin
    #(150000 * 10);
    nFails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(negedge clk);
    // R1 reset state
    check(swEn == 0, "R1", "swEn", swEn, 0);
    check(faultCause == 3'd2, "R1", "faultCause", faultCause, 2);
    check(batOvCount == 0, "R1", "batOvCount", batOvCount, 0);
    check(lockedOff == 0, "R1", "lockedOff", lockedOff, 0);
    rstN = 1'b1;

    // R3 power-up blanking
    pg = 1;
    step(BLANK + 2, "R3");
    check(swEn == 0, "R3", "swEn one edge early", swEn, 0);
    step(1, "R3");
    check(swEn == 1, "R3", "swEn at blank end", swEn, 1);

    // R2 R10 over-temperature pulsing
    hot = 1; step(2, "R2");
    check(swEn == 1, "R2", "swEn before third edge", swEn, 1);
    step(1, "R10");
    check(swEn == 0, "R10", "swEn hot", swEn, 0);
    hot = 0; step(3, "R10");
    check(swEn == 1, "R10", "swEn hot cleared", swEn, 1);

    // R4 input over-voltage with restart of recovery
    ov = 1; step(5, "R2");
    check(swEn == 0 && faultCause == 3'd3, "R2", "ov off cause", faultCause, 3);
    ov = 0; step(10, "R4");
    ov = 1; step(2, "R4");
    ov = 0; step(RECOV + 2, "R4");
    check(swEn == 0, "R4", "swEn one edge before recovery", swEn, 0);
    step(1, "R4");
    check(swEn == 1, "R4", "swEn after recovery", swEn, 1);

    // R5 short battery pulse ignored
    bat = 1; step(BQUAL - 1, "R5");
    bat = 0; step(6, "R5");
    check(swEn == 1, "R5", "swEn short pulse", swEn, 1);
    check(batOvCount == 0, "R5", "count short pulse", batOvCount, 0);

    // R5 R7 R6 qualified battery event
    bat = 1; step(BQUAL + 3, "R5");
    check(swEn == 0 && faultCause == 3'd5, "R5", "bat cause", faultCause, 5);
    check(batOvCount == 1, "R7", "count after one event", batOvCount, 1);
    step(20, "R7");
    check(batOvCount == 1, "R7", "count stays for long event", batOvCount, 1);
    bat = 0; step(4, "R6");
    check(swEn == 1, "R6", "swEn after bat clears", swEn, 1);

    // R2 reverse lockout and R11 priority
    lock = 1; step(3, "R2");
    check(faultCause == 3'd6 && swEn == 0, "R2", "lockout cause", faultCause, 6);
    hot = 1; step(3, "R11");
    check(faultCause == 3'd4, "R11", "hot over lockout", faultCause, 4);
    hot = 0; lock = 0; step(3, "R11");
    check(faultCause == 3'd0 && swEn == 1, "R12", "no cause enabled", faultCause, 0);

    // R8 reach the latch limit
    for (int k = 0; k < NLATCH - 1; k++) begin
      bat = 1; step(BQUAL + 3, "R7");
      bat = 0; step(4, "R7");
    end
    check(batOvCount == NLATCH, "R8", "count at limit", batOvCount, NLATCH);
    check(lockedOff == 1, "R8", "lockedOff", lockedOff, 1);
    step(50, "R8");
    check(swEn == 0 && faultCause == 3'd1, "R8", "stays off", faultCause, 1);
    bat = 1; step(BQUAL + 5, "R8"); bat = 0; step(5, "R8");
    check(batOvCount == NLATCH, "R8", "count frozen", batOvCount, NLATCH);

    // R9 power cycle clears latch
    pg = 0; step(4, "R9");
    check(batOvCount == 0 && lockedOff == 0, "R9", "cleared", batOvCount, 0);
    pg = 1; step(BLANK + 2, "R9");
    check(swEn == 0, "R9", "blanking rerun", swEn, 0);
    step(1, "R9");
    check(swEn == 1, "R9", "enabled after power cycle", swEn, 1);

    // random mix compared against the model each cycle
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 399) == 0) pg = ~pg;
      if ($urandom_range(0, 59) == 0)  ov = ~ov;
      if ($urandom_range(0, 13) == 0)  bat = ~bat;
      if ($urandom_range(0, 49) == 0)  hot = ~hot;
      if ($urandom_range(0, 49) == 0)  lock = ~lock;
      step(1, "R11 R12");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule